// File: doc/BRIEF.md
# Bus-Invert Hamming Codec

This block codes a parallel on-chip bus for both lower switching activity and single-error correction. On the send side, each data word is compared with the data bits last driven onto the bus. If more than half of them would toggle, the word is driven complemented and a single invert flag is raised. Both the data bits and the invert flag are then covered by a systematic Hamming code.

To keep the encoder shallow, the parity bits are formed from the raw input word while the invert decision is still being made. Once the flag is known, only those parity bits whose group needs it are corrected. On the receive side, the word is first repaired with its syndrome, and the repaired invert flag then restores the original data.

Encoder and decoder share one module but are independent: a word written on `busWord` may travel over wires and come back, possibly corrupted, on `rxWord`.

Top module: `bih_codec`

## Requirements
- R1: When the input word differs from the stored previous sent data in more than DATA_W/2 bits, the encoder drives the complemented word on busWord[DATA_W-1:0] and sets the invert flag busWord[DATA_W] to 1.
- R2: When the word differs in DATA_W/2 bits or fewer, including exactly half, the data is driven unchanged and busWord[DATA_W] is 0.
- R3: The previous-sent register holds the data bits actually driven (after inversion). It resets to all zeros and changes only in a cycle with inValid high; input words presented while inValid is low have no effect on later invert decisions.
- R4: The bus word is a Hamming codeword of the sent bits, defined as follows.
  - Protected bit j is data bit j for j < DATA_W, and the invert flag for j = DATA_W.
  - Protected bit j takes the (j+1)-th integer at or above 3 that is not a power of two as its code position.
  - There are P parity bits, where P is the smallest value with 2^P >= DATA_W+1+P+1. This gives P = 4 and a 13-bit word for DATA_W = 8.
  - Parity bit p sits at busWord[DATA_W+1+p] and is the XOR of the protected bits whose code position has bit p set.
- R5: busWord and busValid update on the clock edge after a cycle with inValid high; busValid is high for exactly that one cycle, and busWord holds its value while inValid is low.
- R6: An error-free received word yields the original data on outData one cycle after rxValid, with corrected low.
- R7: A received word with any single bit flipped (data, invert flag or parity) yields the original data on outData one cycle after rxValid, with corrected high for that cycle.
- R8: outValid and corrected are high only in the cycle after a cycle with rxValid high; outData holds its value while rxValid is low.
- R9: After reset, busWord, outData, busValid, outValid and corrected are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Input word is to be encoded this cycle |
| inData | input | DATA_W | Data word to encode |
| busValid | output | 1 | busWord carries a new word this cycle |
| busWord | output | DATA_W+1+P | Encoded word driven onto the bus |
| rxValid | input | 1 | rxWord is to be decoded this cycle |
| rxWord | input | DATA_W+1+P | Word received from the bus |
| outValid | output | 1 | outData carries a newly decoded word |
| outData | output | DATA_W | Corrected, de-inverted data |
| corrected | output | 1 | A nonzero syndrome was found for the current word |

## Verification
On every cycle, the assertions check the following:
- every valid bus word has a zero syndrome;
- the driven data never toggles more than half of its bits against the previous bus word;
- the handshake timing holds on both sides;
- the bus and output registers hold steady when idle.

Only the bench scenarios can show whether the right words are chosen for inversion. Those scenarios cover the exact-half tie, idle words not disturbing the stored history, and back-to-back words. The bench also shows that every single-bit error in every field position is repaired back to the original data, which a per-cycle property cannot show without its own copy of the codec.

// File: rtl/bih_pkg.sv
package bih_pkg;

  typedef struct packed {
    logic encLoad;
    logic decLoad;
  } bihStrobe_t;

  // Code position of protected bit idx: the idx-th integer >= 3 that is not a power of two.
  function automatic int hamPos(input int idx);
    int seen;
    seen = 0;
    for (int pos = 3; pos < 1024; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        if (seen == idx) return pos;
        seen++;
      end
    end
    return 0;
  endfunction

  // Smallest parity count that covers nProt protected bits.
  function automatic int parityCount(input int nProt);
    for (int m = 1; m < 31; m++) begin
      if ((1 << m) >= nProt + m + 1) return m;
    end
    return 31;
  endfunction

  function automatic bit coversBit(input int idx, input int p);
    return ((hamPos(idx) >> p) & 1) == 1;
  endfunction

  // Parity p needs the invert flag folded in when it covers an odd count of data bits,
  // and once more when it also covers the flag's own position.
  function automatic bit fixNeeded(input int nData, input int p);
    bit acc;
    acc = 1'b0;
    for (int j = 0; j < nData; j++) begin
      if (coversBit(j, p)) acc = ~acc;
    end
    if (coversBit(nData, p)) acc = ~acc;
    return acc;
  endfunction

endpackage

// File: rtl/bih_ctrl.sv
module bih_ctrl
  import bih_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       rxValid,
  output bihStrobe_t stb,
  output logic       busValid,
  output logic       outValid
);

  assign stb.encLoad = inValid;
  assign stb.decLoad = rxValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busValid <= 1'b0;
      outValid <= 1'b0;
    end else begin
      busValid <= inValid;
      outValid <= rxValid;
    end
  end

endmodule

// File: rtl/bih_datapath.sv
module bih_datapath
  import bih_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PAR_W  = 4,
  parameter int CW     = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  bihStrobe_t        stb,
  input  logic [DATA_W-1:0] inData,
  input  logic [CW-1:0]     rxWord,
  output logic [CW-1:0]     busWord,
  output logic [DATA_W-1:0] outData,
  output logic              corrected
);

  localparam int PROT_W = DATA_W + 1;
  localparam int CNT_W  = $clog2(DATA_W + 1);
  localparam int HALF   = DATA_W / 2;

  logic [DATA_W-1:0] prevSent;
  logic [DATA_W-1:0] diffBits;
  logic [DATA_W-1:0] sentData;
  logic [CNT_W-1:0]  diffCount;
  logic              invBit;
  logic [PAR_W-1:0]  rawPar;
  logic [PAR_W-1:0]  fixPar;
  logic [PAR_W-1:0]  syndrome;
  logic [PROT_W-1:0] flipMask;
  logic [PROT_W-1:0] fixedProt;
  logic [CW-1:0]     busReg;
  logic [DATA_W-1:0] outReg;

  // Invert decision: toggle count against the last driven data bits.
  assign diffBits = inData ^ prevSent;

  always_comb begin
    diffCount = '0;
    for (int i = 0; i < DATA_W; i++) begin
      diffCount = diffCount + CNT_W'(diffBits[i]);
    end
  end

  assign invBit   = diffCount > CNT_W'(HALF);
  assign sentData = inData ^ {DATA_W{invBit}};

  // Parity from raw data in parallel with the decision, then a one-gate fix-up.
  for (genvar p = 0; p < PAR_W; p++) begin : g_par
    localparam bit FIX = fixNeeded(DATA_W, p);
    logic [PROT_W-1:0] grpMask;
    for (genvar j = 0; j < PROT_W; j++) begin : g_bit
      assign grpMask[j] = coversBit(j, p);
    end
    assign rawPar[p]   = ^(inData & grpMask[DATA_W-1:0]);
    assign fixPar[p]   = rawPar[p] ^ (invBit & FIX);
    assign syndrome[p] = rxWord[PROT_W+p] ^ (^(rxWord[PROT_W-1:0] & grpMask));
  end

  // Syndrome points at the protected bit to repair; parity-only hits match none.
  for (genvar j = 0; j < PROT_W; j++) begin : g_fix
    localparam logic [PAR_W-1:0] POS = PAR_W'(hamPos(j));
    assign flipMask[j] = (syndrome == POS);
  end

  assign fixedProt = rxWord[PROT_W-1:0] ^ flipMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevSent  <= '0;
      busReg    <= '0;
      outReg    <= '0;
      corrected <= 1'b0;
    end else begin
      if (stb.encLoad) begin
        prevSent <= sentData;
        busReg   <= {fixPar, invBit, sentData};
      end
      if (stb.decLoad) begin
        outReg <= fixedProt[DATA_W-1:0] ^ {DATA_W{fixedProt[DATA_W]}};
      end
      corrected <= stb.decLoad & (|syndrome);
    end
  end

  assign busWord = busReg;
  assign outData = outReg;

endmodule

// File: rtl/bih_codec.sv
module bih_codec
  import bih_pkg::*;
#(
  parameter  int DATA_W = 8,
  localparam int PAR_W  = parityCount(DATA_W + 1),
  localparam int CW     = DATA_W + 1 + PAR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  output logic              busValid,
  output logic [CW-1:0]     busWord,
  input  logic              rxValid,
  input  logic [CW-1:0]     rxWord,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic              corrected
);

  bihStrobe_t stb;

  bih_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .rxValid  (rxValid),
    .stb      (stb),
    .busValid (busValid),
    .outValid (outValid)
  );

  bih_datapath #(
    .DATA_W (DATA_W),
    .PAR_W  (PAR_W),
    .CW     (CW)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .inData    (inData),
    .rxWord    (rxWord),
    .busWord   (busWord),
    .outData   (outData),
    .corrected (corrected)
  );

endmodule

// File: rtl/bih_checker.sv
module bih_checker
  import bih_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PAR_W  = 4,
  parameter int CW     = 13
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              busValid,
  input logic [CW-1:0]     busWord,
  input logic              rxValid,
  input logic              outValid,
  input logic [DATA_W-1:0] outData,
  input logic              corrected
);

  logic [PAR_W-1:0] chkSyn;

  always_comb begin
    chkSyn = '0;
    for (int p = 0; p < PAR_W; p++) begin
      chkSyn[p] = busWord[DATA_W+1+p];
      for (int j = 0; j <= DATA_W; j++) begin
        if (coversBit(j, p)) chkSyn[p] = chkSyn[p] ^ busWord[j];
      end
    end
  end

  AST_CODEWORD_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    busValid |-> (chkSyn == '0));  // R4
  AST_TOGGLE_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    busValid |-> ($countones(busWord[DATA_W-1:0] ^ $past(busWord[DATA_W-1:0])) <= DATA_W / 2));  // R2
  AST_ENC_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> busValid);  // R5
  AST_ENC_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!busValid && $stable(busWord)));  // R5
  AST_DEC_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> outValid);  // R6
  AST_DEC_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !rxValid |=> (!outValid && $stable(outData)));  // R8
  AST_FLAG_WITH_VALID: assert property (@(posedge clk) disable iff (!rstN)
    corrected |-> outValid);  // R8

endmodule

bind bih_codec bih_checker #(
  .DATA_W (DATA_W),
  .PAR_W  (PAR_W),
  .CW     (CW)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .inValid   (inValid),
  .busValid  (busValid),
  .busWord   (busWord),
  .rxValid   (rxValid),
  .outValid  (outValid),
  .outData   (outData),
  .corrected (corrected)
);

// File: tb/test_bih_codec.sv
module test_bih_codec;

  localparam int D = 8;

  function automatic int benchParCount(input int n);
    for (int m = 1; m < 31; m++) if ((1 << m) >= n + m + 1) return m;
    return 31;
  endfunction

  localparam int PW = benchParCount(D + 1);
  localparam int CW = D + 1 + PW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          inValid = 1'b0;
  logic [D-1:0]  inData = '0;
  logic          busValid;
  logic [CW-1:0] busWord;
  logic          rxValid = 1'b0;
  logic [CW-1:0] rxWord = '0;
  logic          outValid;
  logic [D-1:0]  outData;
  logic          corrected;

  int total = 0;
  int bad = 0;
  logic [D-1:0] modelPrev = '0;

  always #10 clk = ~clk;

  bih_codec #(.DATA_W(D)) i_bih_codec (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .busValid(busValid), .busWord(busWord), .rxValid(rxValid), .rxWord(rxWord),
    .outValid(outValid), .outData(outData), .corrected(corrected)
  );

  function automatic int codePos(input int idx);
    int k;
    k = 0;
    for (int v = 3; v < 1024; v++) begin
      if ((v & (v - 1)) != 0) begin
        if (k == idx) return v;
        k++;
      end
    end
    return 0;
  endfunction

  // Reference: decide, invert, then Hamming-encode the whole sent word.
  function automatic logic [CW-1:0] refEnc(input logic [D-1:0] d, input logic [D-1:0] prev);
    logic          inv;
    logic [D:0]    prot;
    logic [PW-1:0] par;
    inv  = $countones(d ^ prev) > D / 2;
    prot = {inv, inv ? ~d : d};
    par  = '0;
    for (int p = 0; p < PW; p++)
      for (int j = 0; j <= D; j++)
        if (((codePos(j) >> p) & 1) == 1) par[p] = par[p] ^ prot[j];
    return {par, prot};
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic encodeOne(input logic [D-1:0] d, input string req);
    logic [CW-1:0] exp;
    exp = refEnc(d, modelPrev);
    @(negedge clk); inData = d; inValid = 1'b1;
    @(negedge clk); inValid = 1'b0;
    check(busWord == exp, req, 64'(busWord), 64'(exp));
    check(busValid == 1'b1, "R5", 64'(busValid), 64'd1);
    modelPrev = exp[D-1:0];
  endtask

  task automatic decodeOne(input logic [CW-1:0] w, input logic [D-1:0] expD, input logic expC, input string req);
    @(negedge clk); rxWord = w; rxValid = 1'b1;
    @(negedge clk); rxValid = 1'b0;
    check(outData == expD, req, 64'(outData), 64'(expD));
    check(corrected == expC, req, 64'(corrected), 64'(expC));
    check(outValid == 1'b1, "R8", 64'(outValid), 64'd1);
  endtask

  task automatic testReset();
    @(negedge clk);
    check(busWord == '0 && outData == '0, "R9", 64'({busWord, outData}), 64'd0);
    check({busValid, outValid, corrected} == 3'b000, "R9", 64'({busValid, outValid, corrected}), 64'd0);
  endtask

  task automatic testInvertChoice();
    encodeOne(8'h03, "R2");
    check(busWord[D] == 1'b0, "R2", 64'(busWord[D]), 64'd0);
    encodeOne(8'hFC, "R1");
    check(busWord[D] == 1'b1 && busWord[D-1:0] == 8'h03, "R1", 64'(busWord[D:0]), 64'h103);
    encodeOne(8'h0C, "R2");
    check(busWord[D] == 1'b0 && busWord[D-1:0] == 8'h0C, "R2", 64'(busWord[D:0]), 64'h00C);
  endtask

  task automatic testIdle();
    logic [CW-1:0] held;
    held = busWord;
    @(negedge clk); inData = 8'hFF;
    repeat (3) @(negedge clk);
    check(busWord == held, "R5", 64'(busWord), 64'(held));
    check(busValid == 1'b0, "R5", 64'(busValid), 64'd0);
    // prev must still be 0x0C: 0xF3 differs in all bits and must be inverted
    encodeOne(8'hF3, "R3");
    check(busWord[D] == 1'b1, "R3", 64'(busWord[D]), 64'd1);
  endtask

  task automatic testBackToBack();
    logic [CW-1:0] e1;
    logic [CW-1:0] e2;
    e1 = refEnc(8'hA5, modelPrev);
    e2 = refEnc(8'h5A, e1[D-1:0]);
    @(negedge clk); inData = 8'hA5; inValid = 1'b1;
    @(negedge clk); inData = 8'h5A;
    check(busWord == e1, "R3", 64'(busWord), 64'(e1));
    @(negedge clk); inValid = 1'b0;
    check(busWord == e2, "R3", 64'(busWord), 64'(e2));
    modelPrev = e2[D-1:0];
  endtask

  task automatic testSweep();
    for (int i = 0; i < 24; i++) begin
      encodeOne(8'((i * 37 + 11) ^ (i << 3)), "R4");
    end
  endtask

  task automatic testDecodeClean();
    decodeOne(refEnc(8'h5A, 8'h50), 8'h5A, 1'b0, "R6");
    decodeOne(refEnc(8'hF1, 8'h00), 8'hF1, 1'b0, "R6");
    encodeOne(8'h6E, "R4");
    decodeOne(busWord, 8'h6E, 1'b0, "R6");
  endtask

  task automatic testSingleErrors();
    logic [D-1:0] words [3];
    logic [D-1:0] prevs [3];
    logic [CW-1:0] w;
    words[0] = 8'h5A; prevs[0] = 8'h50;
    words[1] = 8'hF1; prevs[1] = 8'h00;
    words[2] = 8'h3C; prevs[2] = 8'hC3;
    for (int k = 0; k < 3; k++) begin
      w = refEnc(words[k], prevs[k]);
      for (int b = 0; b < CW; b++) begin
        decodeOne(w ^ (CW'(1) << b), words[k], 1'b1, "R7");
      end
    end
  endtask

  task automatic testFlagClears();
    logic [D-1:0] held;
    held = outData;
    @(negedge clk); rxWord = '1;
    @(negedge clk);
    check({outValid, corrected} == 2'b00, "R8", 64'({outValid, corrected}), 64'd0);
    check(outData == held, "R8", 64'(outData), 64'(held));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testInvertChoice();
    testIdle();
    testBackToBack();
    testSweep();
    testDecodeClean();
    testSingleErrors();
    testFlagClears();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule